// File: doc/BRIEF.md
# Partitioned Arithmetic Unit

This block is a 36-bit arithmetic element whose carry structure is reshaped on every operation. The datapath is built from four 9-bit quarters. A 3-bit configuration code arrives with each pair of operands and groups the quarters into lanes. The lanes can form one 36-bit word, two 18-bit halves, four 9-bit quarters, or a mix of one 18-bit lane and two 9-bit lanes. Every lane computes at the same time and independently of the others. Carries move between quarters only inside a lane. Each lane reports its own carry and signed overflow.

The operation select chooses add, subtract, bitwise AND or bitwise OR. The result and the flags are captured in one output register stage. They appear on the clock edge after the operands are presented with `in_valid` high. Because the configuration travels with each operation, consecutive operations may use different lane groupings with no penalty.

Top module: `pau_core`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result`, `carry_q` and `ovf_q` are cleared to zero.
- R2: `out_valid` equals the value of `in_valid` one clock earlier. `result`, `carry_q` and `ovf_q` take a new value only on an edge where `in_valid` is high, and they hold their value otherwise.
- R3: `cfg` 3'b000, and the unused codes 3'b101, 3'b110 and 3'b111, form a single 36-bit lane (bits 35:0).
- R4: `cfg` 3'b001 forms two 18-bit lanes, bits 17:0 and bits 35:18, with no carry between them.
- R5: `cfg` 3'b010 forms four 9-bit lanes, bits 8:0, 17:9, 26:18 and 35:27.
- R6: `cfg` 3'b011 forms one 18-bit lane at bits 35:18 and two 9-bit lanes at bits 17:9 and 8:0.
- R7: `cfg` 3'b100 forms 9-bit lanes at bits 35:27 and 26:18 and one 18-bit lane at bits 17:0.
- R8: `op` 2'b00 adds A+B in each lane. `op` 2'b01 computes A + ~B + 1 in each lane, so the carry flag is 1 when no borrow occurs.
- R9: `carry_q[k]` covers bits 9k+8:9k. For add and subtract it holds the carry out of the top bit of the lane that contains quarter k, so every quarter of a lane shows the same value.
- R10: `ovf_q[k]` holds the two's-complement overflow of the lane that contains quarter k, judged at that lane's top bit, and is the same for every quarter of the lane.
- R11: `op` 2'b10 gives A AND B and `op` 2'b11 gives A OR B over all 36 bits. For both logic operations `carry_q` and `ovf_q` are zero.
- R12: The configuration may change on every operation. No operation's result depends on an earlier operation's configuration or operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands, op and cfg are valid this cycle |
| opa | input | 36 | Operand A |
| opb | input | 36 | Operand B |
| op | input | 2 | 00 add, 01 subtract, 10 AND, 11 OR |
| cfg | input | 3 | Lane grouping code |
| out_valid | output | 1 | Registered outputs hold a fresh result |
| result | output | 36 | Registered lane results |
| carry_q | output | 4 | Per-quarter carry flag, copied across each lane |
| ovf_q | output | 4 | Per-quarter overflow flag, copied across each lane |

## Verification
The assertions expect `op` and `cfg` to be known, two-state values whenever `in_valid` is high. They also expect reset to be held for at least one edge before operation starts. The stimulus drives only defined values, and it holds `rst` for several cycles before releasing it. It covers all eight configuration codes and all four operations, together with cycles where `in_valid` is low. Directed operands sit on the quarter boundaries (all ones, the signed maximum in a quarter, equal operands for subtraction). These values show directly whether a carry is kept inside its lane or leaks into the next one.

// File: rtl/pau_pkg.sv
package pau_pkg;

    localparam int QW = 9;
    localparam int NQ = 4;
    localparam int DW = QW * NQ;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        CFG_FULL   = 3'b000,
        CFG_HALVES = 3'b001,
        CFG_QUARTS = 3'b010,
        CFG_HI18   = 3'b011,
        CFG_LO18   = 3'b100
    } cfg_e;

    typedef logic [NQ-1:0] qmask_t;

    typedef struct packed {
        logic [DW-1:0] data;
        qmask_t        carry;
        qmask_t        ovf;
    } pau_res_t;

    // bit k set: quarter k continues the lane of quarter k-1 (bit 0 unused)
    function automatic qmask_t link_of(input logic [2:0] code);
        qmask_t m;
        case (code)
            CFG_FULL:   m = 4'b1110;
            CFG_HALVES: m = 4'b1010;
            CFG_QUARTS: m = 4'b0000;
            CFG_HI18:   m = 4'b1000;
            CFG_LO18:   m = 4'b0010;
            default:    m = 4'b1110;
        endcase
        return m;
    endfunction

    // index of the highest quarter in the lane holding quarter q
    function automatic int top_of(input qmask_t link, input int q);
        int   t;
        logic run;
        t   = q;
        run = 1'b1;
        for (int j = 0; j < NQ; j++) begin
            if (j > q) begin
                if (run && link[j]) t = j;
                else                run = 1'b0;
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/pau_lane_map.sv
module pau_lane_map
    import pau_pkg::*;
(
    input  logic [2:0] cfg,
    output qmask_t     link,
    output qmask_t     lane_low
);
    always_comb begin
        link     = link_of(cfg);
        lane_low = ~link;
    end
endmodule

// File: rtl/pau_quarter.sv
module pau_quarter #(
    parameter int QW = 9
) (
    input  logic [QW-1:0] a,
    input  logic [QW-1:0] b,
    input  logic          cin,
    output logic [QW-1:0] sum,
    output logic          cout,
    output logic          ovf
);
    logic [QW:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{QW{1'b0}}, cin};
        sum  = wide[QW-1:0];
        cout = wide[QW];
        ovf  = (a[QW-1] == b[QW-1]) && (wide[QW-1] != a[QW-1]);
    end
endmodule

// File: rtl/pau_flag_spread.sv
module pau_flag_spread
    import pau_pkg::*;
(
    input  qmask_t link,
    input  qmask_t cout_raw,
    input  qmask_t ovf_raw,
    input  logic   arith,
    output qmask_t carry_q,
    output qmask_t ovf_q
);
    always_comb begin
        carry_q = '0;
        ovf_q   = '0;
        for (int q = 0; q < NQ; q++) begin
            carry_q[q] = arith & cout_raw[top_of(link, q)];
            ovf_q[q]   = arith & ovf_raw[top_of(link, q)];
        end
    end
endmodule

// File: rtl/pau_core.sv
module pau_core
    import pau_pkg::*;
#(
    parameter int LQW = pau_pkg::QW,
    parameter int LNQ = pau_pkg::NQ
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [LQW*LNQ-1:0] opa,
    input  logic [LQW*LNQ-1:0] opb,
    input  logic [1:0]         op,
    input  logic [2:0]         cfg,
    output logic               out_valid,
    output logic [LQW*LNQ-1:0] result,
    output logic [LNQ-1:0]     carry_q,
    output logic [LNQ-1:0]     ovf_q
);
    localparam int W = LQW * LNQ;

    op_e          opc;
    logic         sub;
    logic         arith;
    qmask_t       link;
    qmask_t       lane_low;
    logic [W-1:0] bx;
    logic [W-1:0] sum;
    logic [LNQ-1:0] cin;
    logic [LNQ-1:0] cout_raw;
    logic [LNQ-1:0] ovf_raw;
    qmask_t       carry_n;
    qmask_t       ovf_n;
    pau_res_t     nxt;
    pau_res_t     cur;

    assign opc   = op_e'(op);
    assign sub   = (opc == OP_SUB);
    assign arith = (opc == OP_ADD) || (opc == OP_SUB);
    assign bx    = sub ? ~opb : opb;

    pau_lane_map u_map (
        .cfg      (cfg),
        .link     (link),
        .lane_low (lane_low)
    );

    for (genvar q = 0; q < LNQ; q++) begin : g_q
        if (q == 0) begin : g_first
            assign cin[q] = sub;
        end else begin : g_rest
            assign cin[q] = lane_low[q] ? sub : cout_raw[q-1];
        end
        pau_quarter #(.QW(LQW)) u_quarter (
            .a    (opa[q*LQW +: LQW]),
            .b    (bx[q*LQW +: LQW]),
            .cin  (cin[q]),
            .sum  (sum[q*LQW +: LQW]),
            .cout (cout_raw[q]),
            .ovf  (ovf_raw[q])
        );
    end

    pau_flag_spread u_flags (
        .link     (link),
        .cout_raw (cout_raw),
        .ovf_raw  (ovf_raw),
        .arith    (arith),
        .carry_q  (carry_n),
        .ovf_q    (ovf_n)
    );

    always_comb begin
        nxt.carry = carry_n;
        nxt.ovf   = ovf_n;
        case (opc)
            OP_AND:  nxt.data = opa & opb;
            OP_OR:   nxt.data = opa | opb;
            default: nxt.data = sum;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) cur <= nxt;
        end
    end

    assign result  = cur.data;
    assign carry_q = cur.carry;
    assign ovf_q   = cur.ovf;

    // R2: valid follows input one cycle later; idle cycles keep outputs
    a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(carry_q) && $stable(ovf_q)));
    // R11: logic ops clear flags and give bitwise results
    a_r11_logic_flags: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[1]) |=> (carry_q == '0 && ovf_q == '0));
    a_r11_and: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b10) |=> (result == ($past(opa) & $past(opb))));
    // R3: a single lane shows uniform flags
    a_r3_uniform_flags: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg == 3'b000) |=>
        (($countones(carry_q) == 0 || carry_q == '1) &&
         ($countones(ovf_q) == 0 || ovf_q == '1)));
    // R4: halves carry paired flags
    a_r4_half_flags: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg == 3'b001) |=>
        (carry_q[1] == carry_q[0] && carry_q[3] == carry_q[2] &&
         ovf_q[1] == ovf_q[0] && ovf_q[3] == ovf_q[2]));
    // R8: A - A is zero with no borrow in every lane
    a_r8_self_sub: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b01 && opa == opb) |=>
        (result == '0 && carry_q == '1 && ovf_q == '0));
endmodule

// File: tb/pau_core_bench.sv
module pau_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [35:0] opa = '0;
    logic [35:0] opb = '0;
    logic [1:0]  op = '0;
    logic [2:0]  cfg = '0;
    logic        out_valid;
    logic [35:0] result;
    logic [3:0]  carry_q;
    logic [3:0]  ovf_q;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [35:0] exp_r = '0;
    logic [3:0]  exp_c = '0;
    logic [3:0]  exp_o = '0;
    logic        exp_v = 1'b0;
    string       exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pau_core u_pau_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
        .op(op), .cfg(cfg), .out_valid(out_valid), .result(result),
        .carry_q(carry_q), .ovf_q(ovf_q)
    );

    // behavioural reference: lane widths in quarters, listed from bit 0 up
    function automatic void model(input logic [35:0] a, input logic [35:0] b,
                                  input logic [1:0] o, input logic [2:0] c,
                                  output logic [35:0] r, output logic [3:0] cf,
                                  output logic [3:0] of);
        int wq[4];
        int n;
        int lo;
        case (c)
            3'b001: begin wq = '{2, 2, 0, 0}; n = 2; end
            3'b010: begin wq = '{1, 1, 1, 1}; n = 4; end
            3'b011: begin wq = '{1, 1, 2, 0}; n = 3; end
            3'b100: begin wq = '{2, 1, 1, 0}; n = 3; end
            default: begin wq = '{4, 0, 0, 0}; n = 1; end
        endcase
        cf = '0;
        of = '0;
        if (o == 2'b10) begin r = a & b; return; end
        if (o == 2'b11) begin r = a | b; return; end
        r  = '0;
        lo = 0;
        for (int i = 0; i < n; i++) begin
            longint unsigned mask, av, bv, s, sm;
            int w;
            w    = 9 * wq[i];
            mask = (64'd1 << w) - 1;
            av   = (64'(a) >> (9 * lo)) & mask;
            bv   = (64'(b) >> (9 * lo)) & mask;
            if (o == 2'b01) bv = (~bv) & mask;
            s    = av + bv + ((o == 2'b01) ? 64'd1 : 64'd0);
            sm   = s & mask;
            for (int k = 0; k < w; k++) r[9*lo + k] = sm[k];
            for (int q = lo; q < lo + wq[i]; q++) begin
                cf[q] = s[w];
                of[q] = (av[w-1] == bv[w-1]) && (sm[w-1] != av[w-1]);
            end
            lo = lo + wq[i];
        end
    endfunction

    function automatic string tag_of(input logic [1:0] o, input logic [2:0] c);
        string t;
        case (c)
            3'b001:  t = "R4";
            3'b010:  t = "R5";
            3'b011:  t = "R6";
            3'b100:  t = "R7";
            default: t = "R3";
        endcase
        if (o == 2'b01) t = {t, "/R8"};
        if (o[1])       t = {t, "/R11"};
        return t;
    endfunction

    task automatic check_outputs();
        checks++;
        if (out_valid !== exp_v) begin
            errors++;
            $display("FAIL R2 out_valid: actual %b expected %b", out_valid, exp_v);
        end
        checks++;
        if (result !== exp_r) begin
            errors++;
            $display("FAIL %s result: actual %h expected %h", exp_tag, result, exp_r);
        end
        checks++;
        if (carry_q !== exp_c) begin
            errors++;
            $display("FAIL R9 (%s) carry_q: actual %b expected %b", exp_tag, carry_q, exp_c);
        end
        checks++;
        if (ovf_q !== exp_o) begin
            errors++;
            $display("FAIL R10 (%s) ovf_q: actual %b expected %b", exp_tag, ovf_q, exp_o);
        end
    endtask

    // one cycle: check what the last edge produced, then drive the next op
    task automatic step(input logic [35:0] a, input logic [35:0] b,
                        input logic [1:0] o, input logic [2:0] c,
                        input logic v, input string extra);
        @(negedge clk);
        check_outputs();
        in_valid = v;
        opa = a; opb = b; op = o; cfg = c;
        exp_v = v;
        if (v) begin
            model(a, b, o, c, exp_r, exp_c, exp_o);
            exp_tag = {tag_of(o, c), extra};
        end else begin
            exp_tag = "R2";
        end
    endtask

    function automatic logic [35:0] pick(input int sel);
        case (sel % 6)
            0: return 36'hF_FFFF_FFFF;
            1: return 36'h0_0000_0001;
            2: return 36'h7_FBFD_FEFF;
            3: return 36'h8_0402_0100;
            4: return 36'h0_0000_0000;
            default: return {$urandom, $urandom} & 36'hF_FFFF_FFFF;
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || carry_q !== '0 || ovf_q !== '0) begin
            errors++;
            $display("FAIL R1 reset: actual %b %h %b %b expected 0 0 0 0",
                     out_valid, result, carry_q, ovf_q);
        end
        rst = 1'b0;

        // R3: full-width wrap and the unused codes
        step(36'hF_FFFF_FFFF, 36'h1, 2'b00, 3'b000, 1'b1, "");
        step(36'h7_FFFF_FFFF, 36'h1, 2'b00, 3'b101, 1'b1, "");
        step(36'h0_0000_01FF, 36'h1, 2'b00, 3'b111, 1'b1, "");
        // R4: low half overflows without touching the upper half
        step(36'h0_0003_FFFF, 36'h1, 2'b00, 3'b001, 1'b1, "");
        step(36'h0_0001_FFFF, 36'h1, 2'b00, 3'b001, 1'b1, "");
        // R5: every quarter wraps on its own
        step(36'h7_FBFD_FEFF, 36'h0_0804_0201, 2'b00, 3'b010, 1'b1, "");
        step(36'hF_FFFF_FFFF, 36'h0_0804_0201, 2'b00, 3'b010, 1'b1, "");
        // R6 and R7: mixed splits
        step(36'hF_FFFF_FFFF, 36'h0_0804_0201, 2'b00, 3'b011, 1'b1, "");
        step(36'hF_FFFF_FFFF, 36'h0_0804_0201, 2'b00, 3'b100, 1'b1, "");
        // R8: subtraction with borrow and without
        step(36'h0, 36'h0_0804_0201, 2'b01, 3'b010, 1'b1, "");
        step(36'h1_2345_6789, 36'h1_2345_6789, 2'b01, 3'b011, 1'b1, "");
        step(36'h8_0000_0000, 36'h1, 2'b01, 3'b000, 1'b1, "");
        // R11: logic ops
        step(36'hA_AAAA_AAAA, 36'hF_0F0F_0FF0, 2'b10, 3'b010, 1'b1, "");
        step(36'hA_AAAA_AAAA, 36'h5_5555_5555, 2'b11, 3'b001, 1'b1, "");
        // R2: idle cycles hold the last result
        step(36'h1, 36'h1, 2'b00, 3'b010, 1'b0, "");
        step(36'h3, 36'h5, 2'b01, 3'b000, 1'b0, "");
        // R12: configuration changes on every op, same operands
        for (int c = 0; c < 8; c++)
            step(36'hF_FFFF_FFFF, 36'h0_0804_0201, 2'b00, 3'(c), 1'b1, " R12");
        for (int c = 7; c >= 0; c--)
            step(36'h0, 36'h0_0804_0201, 2'b01, 3'(c), 1'b1, " R12");
        // mixed stimulus with boundary-heavy operands
        for (int i = 0; i < 600; i++)
            step(pick($urandom), pick($urandom), 2'($urandom), 3'($urandom),
                 ($urandom % 5) != 0, " R12");
        step(36'h0, 36'h0, 2'b00, 3'b000, 1'b0, "");
        @(negedge clk);
        check_outputs();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule